// File: doc/BRIEF.md
# Multi-format audio serial receiver

The block receives stereo PCM samples from a three-wire serial link made of a bit clock, a frame clock and a serial data line. It supports four framings: left-justified, right-justified, I2S and DSP. In every framing each word is sent most significant bit first. The block can run as a slave, where the remote device drives both clocks and the block samples them into its system-clock domain. It can also run as a master, where it drives both clocks itself from the system clock through a programmable divider. In master mode a stereo frame is 64 bit clocks long.

Static configuration inputs select the framing, the role and the word length. Each completed word is left-aligned in a 32-bit register and presented with a one-cycle valid strobe and a channel flag. Words are accepted only after the frame clock has changed at least once since reset.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, valid_o, right_o, sample_o, bclk_o and lrck_o are all 0.
- R2: With fmt_i=0 (left-justified), the MSB is taken on the first rising bit-clock edge after a frame-clock change. The next W-1 edges supply the remaining bits, and the edges after that are ignored until the next change. A high frame clock means left (right_o=0).
- R3: With fmt_i=1 (right-justified), the LSB is the bit taken on the last rising edge before a frame-clock change, and the MSB is the bit taken W-1 edges earlier. Earlier edges in the half-frame are ignored. The word is presented when the change is seen, and its channel is the level before the change (high means left).
- R4: With fmt_i=2 (I2S), the MSB is taken on the second rising edge after a frame-clock change, and the word occupies W edges. Its final bit may fall on the first edge of the next half-frame. A low frame clock means left.
- R5: With fmt_i=3 (DSP), a rising edge on which the frame clock is first seen high marks the start of a frame. The left word starts on the next edge and the right word follows directly after it. The last right bit may coincide with the next frame mark.
- R6: wlen_i selects the word length W: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32. sample_o holds the word in bits 31 down to 32-W, and its lower bits are 0.
- R7: Each completed word gives exactly one valid_o pulse, one system clock wide, with sample_o and right_o (1 = right channel) valid in that cycle. No word is presented before the first frame-clock change after reset.
- R8: With master_i=0, sclk_i, lrck_i and sdata_i are sampled through two-flop synchronisers. The system clock must run at least four times faster than the bit clock.
- R9: With master_i=1, bclk_o has a half period of div_i+1 system clocks, with div_i of at least 2. lrck_o changes only as bclk_o falls, once every 32 bit clocks, and sclk_i and lrck_i are ignored.
- R10: With master_i=1 and fmt_i=3, lrck_o is high for exactly one bit-clock period in every 64.
- R11: While master_i=0, bclk_o and lrck_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = drive the clocks (master), 0 = follow external clocks (slave) |
| fmt_i | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 I2S, 3 DSP |
| wlen_i | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| div_i | input | DIV_W | Master bit-clock half period minus one, in system clocks |
| sclk_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External frame clock (slave) |
| sdata_i | input | 1 | Serial data |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrck_o | output | 1 | Generated frame clock (master) |
| sample_o | output | 32 | Received word, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a completed word |
| right_o | output | 1 | Channel of the word: 1 = right |

## Verification
Slave streams are tried in each framing, with half-frames longer than the word and junk bits in the unused slots. A capture window that is off by one edge, or that leaks into the unused slots, therefore changes the received value. Right-justified streams are run with both short and full-length words, which checks that the MSB is located from the word length and not from the frame-clock edge. I2S and DSP streams whose final bit falls on the next frame-clock change or frame mark check the boundary handling of the bit counter. Master runs measure the bit-clock period, the half-frame length and the DSP pulse width on the generated clocks, and feed data timed from those clocks.

// File: rtl/aud_rx_pkg.sv
`timescale 1ns/1ps
package aud_rx_pkg;
  localparam int SAMPLE_W = 32;
  localparam int WL_W     = $clog2(SAMPLE_W) + 1;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_RJ  = 2'd1,
    FMT_I2S = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  function automatic logic [WL_W-1:0] wlen_bits(logic [1:0] code);
    case (code)
      2'd0:    return WL_W'(16);
      2'd1:    return WL_W'(20);
      2'd2:    return WL_W'(24);
      default: return WL_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/aud_in_sync.sv
`timescale 1ns/1ps
module aud_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic sdata_i,
  output logic rise_o,
  output logic lrck_o,
  output logic data_o
);
  logic [STAGES:0]   bclk_q;
  logic [STAGES-1:0] lrck_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= '0;
      lrck_q <= '0;
      data_q <= '0;
    end else begin
      bclk_q <= {bclk_q[STAGES-1:0], sclk_i};
      lrck_q <= {lrck_q[STAGES-2:0], lrck_i};
      data_q <= {data_q[STAGES-2:0], sdata_i};
    end
  end

  // frame clock and data leave at the same depth as the bit-clock edge
  assign rise_o = bclk_q[STAGES-1] & ~bclk_q[STAGES];
  assign lrck_o = lrck_q[STAGES-1];
  assign data_o = data_q[STAGES-1];
endmodule

// File: rtl/aud_clk_gen.sv
`timescale 1ns/1ps
module aud_clk_gen #(
  parameter int DIV_W      = 8,
  parameter int FRAME_BITS = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pulse_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_o,
  output logic             lrck_o,
  output logic             rise_o
);
  localparam int BW = $clog2(FRAME_BITS);

  logic [DIV_W-1:0] dcnt_q;
  logic [BW-1:0]    bpos_q, bpos_n;
  logic             bclk_q, lrck_q, rise_q;

  assign bpos_n = bpos_q + BW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      bpos_q <= '0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      rise_q <= 1'b0;
    end else if (!en_i) begin
      dcnt_q <= '0;
      bpos_q <= '0;
      bclk_q <= 1'b0;
      lrck_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (dcnt_q == div_i) begin
        dcnt_q <= '0;
        bclk_q <= ~bclk_q;
        if (!bclk_q) begin
          rise_q <= 1'b1;
        end else begin
          // frame clock moves on the falling bit-clock edge
          bpos_q <= bpos_n;
          lrck_q <= pulse_i ? (bpos_n == BW'(FRAME_BITS - 1)) : bpos_n[BW-1];
        end
      end else begin
        dcnt_q <= dcnt_q + DIV_W'(1);
      end
    end
  end

  assign bclk_o = bclk_q;
  assign lrck_o = lrck_q;
  assign rise_o = rise_q;

  // R11
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bclk_o && !lrck_o));
  // R9
  lrck_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && en_i && !$stable(lrck_o)) |-> $fell(bclk_o));
endmodule

// File: rtl/aud_deframer.sv
`timescale 1ns/1ps
module aud_deframer
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rise_i,
  input  logic                lrck_i,
  input  logic                data_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                right_o
);
  logic [SAMPLE_W-1:0] sh_q, sh_n, word, aligned, sample_q;
  logic [CNT_W-1:0]    cnt_q, idx_c, idx, wl, wl2;
  logic [WL_W-1:0]     wbits;
  logic                lr_q, armed_q, valid_q, right_q;
  logic                edge_lr, restart, cap, last, rgt;

  assign wbits = wlen_bits(wlen_i);
  assign wl    = CNT_W'(wbits);
  assign wl2   = wl << 1;

  always_comb begin
    edge_lr = lrck_i ^ lr_q;
    restart = (fmt_i == FMT_DSP) ? (lrck_i & ~lr_q) : edge_lr;
    idx_c   = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
    idx     = restart ? '0 : idx_c;
    sh_n    = {sh_q[SAMPLE_W-2:0], data_i};
    cap     = 1'b0;
    last    = 1'b0;
    rgt     = 1'b0;
    case (fmt_i)
      FMT_LJ: begin
        cap  = (armed_q | restart) && (idx < wl);
        last = cap && (idx == wl - CNT_W'(1));
        rgt  = ~lrck_i;
      end
      FMT_RJ: begin
        cap  = 1'b1;
        last = armed_q && edge_lr;
        rgt  = ~lr_q;
      end
      FMT_I2S: begin
        // count continues across the change so the last bit may land on it
        cap  = armed_q && (idx_c != '0) && (idx_c <= wl);
        last = cap && (idx_c == wl);
        rgt  = lr_q;
      end
      default: begin
        if ((armed_q | restart) && (idx != '0) && (idx <= wl)) begin
          cap  = 1'b1;
          last = (idx == wl);
        end else if (armed_q && (idx_c > wl) && (idx_c <= wl2)) begin
          cap  = 1'b1;
          last = (idx_c == wl2);
          rgt  = 1'b1;
        end
      end
    endcase
    word    = (fmt_i == FMT_RJ) ? sh_q : sh_n;
    aligned = word << (SAMPLE_W - int'(wbits));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      lr_q     <= 1'b0;
      armed_q  <= 1'b0;
      valid_q  <= 1'b0;
      right_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (rise_i) begin
        lr_q    <= lrck_i;
        cnt_q   <= idx;
        armed_q <= armed_q | restart;
        if (cap) sh_q <= sh_n;
        valid_q <= last;
        if (last) begin
          sample_q <= aligned;
          right_q  <= rgt;
        end
      end
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
  assign right_o  = right_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  short_word_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(wlen_i) == 2'd0) |-> (sample_o[SAMPLE_W-17:0] == '0));
endmodule

// File: rtl/audio_serial_rx.sv
`timescale 1ns/1ps
module audio_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int FRAME_BITS  = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                master_i,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          wlen_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                sclk_i,
  input  logic                lrck_i,
  input  logic                sdata_i,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o,
  output logic                right_o
);
  logic s_rise, s_lrck, s_data;
  logic g_rise, g_lrck, g_bclk;
  logic rise, lrck;

  aud_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .lrck_i (lrck_i),
    .sdata_i(sdata_i),
    .rise_o (s_rise),
    .lrck_o (s_lrck),
    .data_o (s_data)
  );

  aud_clk_gen #(.DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (master_i),
    .pulse_i(fmt_i == FMT_DSP),
    .div_i  (div_i),
    .bclk_o (g_bclk),
    .lrck_o (g_lrck),
    .rise_o (g_rise)
  );

  assign rise   = master_i ? g_rise : s_rise;
  assign lrck   = master_i ? g_lrck : s_lrck;
  assign bclk_o = g_bclk;
  assign lrck_o = g_lrck;

  aud_deframer #(.CNT_W(CNT_W)) u_deframe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .lrck_i  (lrck),
    .data_i  (s_data),
    .fmt_i   (fmt_i),
    .wlen_i  (wlen_i),
    .sample_o(sample_o),
    .valid_o (valid_o),
    .right_o (right_o)
  );
endmodule

// File: tb/tb_audio_serial_rx.sv
`timescale 1ns/1ps
module tb_audio_serial_rx;
  logic        clk, rst_n, master, sclk, lrck, sdata;
  logic [1:0]  fmt, wlen;
  logic [7:0]  div;
  logic        bclk_o, lrck_o, valid_o, right_o;
  logic [31:0] sample_o;

  audio_serial_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .fmt_i(fmt), .wlen_i(wlen),
    .div_i(div), .sclk_i(sclk), .lrck_i(lrck), .sdata_i(sdata),
    .bclk_o(bclk_o), .lrck_o(lrck_o), .sample_o(sample_o), .valid_o(valid_o),
    .right_o(right_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0, W = 16;
  bit cmp_en = 1'b1;
  string cur_req = "R7";
  bit lr_a[4096];
  bit d_a[4096];
  int n = 0;
  logic [31:0] q_s[$];
  bit q_r[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog expired: actual 1 expected 0");
    finish_run();
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n && cmp_en && valid_o) begin
      if (q_s.size() == 0) begin
        chk(1'b0, "R7", "unexpected word", sample_o, 0);
      end else begin
        logic [31:0] es;
        bit er;
        es = q_s.pop_front();
        er = q_r.pop_front();
        chk(sample_o == es, cur_req, "word value", sample_o, es);
        chk(right_o == er, cur_req, "channel flag", right_o, er);
      end
    end
  end

  function automatic logic [31:0] word_for(int k, int wl);
    logic [31:0] w;
    w = (k * 32'h9E3779B1) + 32'h5A5A1234;
    if (wl < 32) w = w & ((32'h1 << wl) - 1);
    return w;
  endfunction

  function automatic bit junk(int p, int seed);
    return ((p * 5 + seed) % 3) == 0;
  endfunction

  task automatic push(logic [31:0] w, bit r);
    q_s.push_back(w << (32 - W));
    q_r.push_back(r);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; master = 1'b0; sclk = 1'b0; lrck = 1'b0; sdata = 1'b0;
    q_s.delete(); q_r.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic build_halves(int H, int nh, int seed);
    n = nh * H + ((fmt == 2'd0) ? 0 : 1);
    for (int p = 0; p < n; p++) begin
      lr_a[p] = ((p / H) % 2) == 0;
      d_a[p]  = junk(p, seed);
    end
    for (int h = 0; h < nh; h++) begin
      logic [31:0] w;
      int base;
      bit lr;
      w = word_for(h + seed, W);
      base = h * H;
      lr = (h % 2) == 0;
      for (int b = 0; b < W; b++) begin
        case (fmt)
          2'd0: d_a[base + b]         = w[W-1-b];
          2'd1: d_a[base + H - W + b] = w[W-1-b];
          default: d_a[base + 1 + b]  = w[W-1-b];
        endcase
      end
      push(w, (fmt == 2'd2) ? lr : !lr);
    end
  endtask

  task automatic build_dsp(int F, int nf, int seed);
    n = nf * F + 1;
    for (int p = 0; p < n; p++) begin
      lr_a[p] = (p % F) == 0;
      d_a[p]  = junk(p, seed);
    end
    for (int f = 0; f < nf; f++) begin
      logic [31:0] wl, wr;
      wl = word_for(2 * f + seed, W);
      wr = word_for(2 * f + 1 + seed, W);
      for (int b = 0; b < W; b++) begin
        d_a[f * F + 1 + b]     = wl[W-1-b];
        d_a[f * F + 1 + W + b] = wr[W-1-b];
      end
      push(wl, 1'b0);
      push(wr, 1'b1);
    end
  endtask

  task automatic play();
    for (int p = 0; p < n; p++) begin
      @(negedge clk);
      lrck = lr_a[p]; sdata = d_a[p];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (20) @(negedge clk);
    chk(q_s.size() == 0, cur_req, "words missing", q_s.size(), 0);
    chk(bclk_o == 1'b0 && lrck_o == 1'b0, "R11", "clock outputs in slave", {bclk_o, lrck_o}, 0);
  endtask

  task automatic run_slave(logic [1:0] f, logic [1:0] wc, int H, int cnt, int seed, string req);
    do_reset();
    fmt = f; wlen = wc; cur_req = req;
    W = (wc == 2'd0) ? 16 : (wc == 2'd1) ? 20 : (wc == 2'd2) ? 24 : 32;
    if (f == 2'd3) build_dsp(H, cnt, seed);
    else build_halves(H, cnt, seed);
    play();
  endtask

  task automatic run_master_lj();
    time t0;
    int pos = 0, changes = 0, pushed = 0;
    logic last = 1'b0;
    logic [31:0] w = '0;
    bit done = 1'b0;
    do_reset();
    fmt = 2'd0; wlen = 2'd0; W = 16; div = 8'd3; cur_req = "R2/R9";
    master = 1'b1;
    @(posedge bclk_o); t0 = $time;
    @(posedge bclk_o);
    chk(($time - t0) == 80, "R9", "bit clock period ns", $time - t0, 80);
    while (!done) begin
      @(negedge bclk_o); #1;
      if (lrck_o !== last) begin
        if (changes > 0) chk(pos + 1 == 32, "R9", "bit clocks per half", pos + 1, 32);
        last = lrck_o; changes++; pos = 0;
        if (pushed == 4) done = 1'b1;
        else begin
          w = word_for(pushed + 40, 16);
          push(w, !lrck_o);
          pushed++;
        end
      end else begin
        pos++;
      end
      if (!done) sdata = (pos < 16) ? w[15-pos] : 1'b1;
    end
    master = 1'b0; sdata = 1'b0;
    repeat (20) @(negedge clk);
    chk(q_s.size() == 0, "R9", "master words missing", q_s.size(), 0);
    chk(bclk_o == 1'b0 && lrck_o == 1'b0, "R11", "clocks after leaving master", {bclk_o, lrck_o}, 0);
  endtask

  task automatic run_master_dsp();
    int hi = 0;
    do_reset();
    cmp_en = 1'b0;
    fmt = 2'd3; wlen = 2'd0; div = 8'd2;
    master = 1'b1;
    @(posedge lrck_o);
    for (int i = 0; i < 65; i++) begin
      @(posedge bclk_o); #1;
      if (lrck_o) hi++;
    end
    chk(hi == 2, "R10", "frame pulse rises in 65 bit clocks", hi, 2);
    chk(lrck_o == 1'b1, "R10", "pulse repeats after 64 bit clocks", lrck_o, 1);
    master = 1'b0;
    repeat (5) @(negedge clk);
    do_reset();
    cmp_en = 1'b1;
  endtask

  initial begin
    fmt = 2'd0; wlen = 2'd0; div = 8'd3;
    do_reset();
    chk(valid_o == 1'b0 && right_o == 1'b0, "R1", "strobe and flag after reset", {valid_o, right_o}, 0);
    chk(sample_o == 32'h0, "R1", "sample after reset", sample_o, 0);
    chk(bclk_o == 1'b0 && lrck_o == 1'b0, "R1", "clocks after reset", {bclk_o, lrck_o}, 0);
    run_slave(2'd0, 2'd0, 20, 4, 1, "R2/R6/R8");
    run_slave(2'd0, 2'd2, 32, 4, 7, "R2/R6");
    run_slave(2'd0, 2'd3, 32, 3, 3, "R2/R6");
    run_slave(2'd1, 2'd1, 32, 4, 5, "R3/R6");
    run_slave(2'd1, 2'd3, 32, 3, 9, "R3");
    run_slave(2'd2, 2'd2, 32, 4, 11, "R4");
    run_slave(2'd2, 2'd3, 32, 3, 13, "R4/R6");
    run_slave(2'd3, 2'd0, 40, 3, 15, "R5");
    run_slave(2'd3, 2'd3, 64, 2, 17, "R5/R6");
    run_master_lj();
    run_master_dsp();
    finish_run();
  end
endmodule